// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block forms the byte that a host receives when it reads a NOR-style flash device. When no internal operation is active, it returns the byte from the array. While a byte program, a pending or running sector erase, or an erase suspend is in effect, it returns a status byte instead. In that byte, bit 7 is a polling bit that tells the host whether the operation is done. Bit 6 inverts on every read while the operation is busy, bit 5 reports a timed-out operation, and bit 3 tells the erase acceptance window apart from a running erase. During a suspend, bit 2 inverts on each read of a suspended sector.

A controller outside this block owns command decoding and the operation sequencing. It presents the current operation as a 3-bit state code. It also supplies the polling bit of the byte being programmed, a timeout flag, and a mask of the sectors that are being erased or are suspended. Each read strobe produces one registered result on the next clock edge. The two toggle bits each live in their own flip-flop. A toggle bit changes only when a read of the matching kind completes, and both toggle bits are cleared whenever the state code says the device is in plain read mode.

Top module: `flash_op_status`

## Requirements
- R1: While `rst` is high and after it is released, `rd_data` is 0x00 and `rd_valid` is 0, and both toggle bits start at 0.
- R2: In state code 0 (read mode), a read returns `array_byte` in `rd_data` on the clock edge after `rd_en`, and `rd_valid` is high for exactly that one cycle.
- R3: In state code 1 (program), a read returns bit 7 = inverse of `prog_msb`, bit 6 = toggle, bit 5 = `fail_flag`, and bits 4..0 = 0. After the state code returns to 0, reads return array data again.
- R4: In state code 2 (erase window open), a read returns bit 7 = 0 and bit 3 = 0. In state code 3 (erase running), a read returns bit 7 = 0 and bit 3 = 1. In both codes bit 5 = `fail_flag`, and bits 4, 2, 1 and 0 are 0.
- R5: For status reads in codes 1, 2 and 3, bit 6 shows the toggle flip-flop, which inverts after each such read. The first read shows 0, and reads in consecutive cycles show alternating values.
- R6: Cycles with no read leave both toggle bits unchanged.
- R7: When `fail_flag` is high, bit 5 of a program or erase status read is 1 and bit 6 keeps inverting on each read.
- R8: In state codes 4 (suspend, reading) and 5 (suspend, programming), a read of an address whose sector is set in `susp_mask` returns {1, bit6 held, 0, 0, 0, bit2 toggle, 0, 0}. The sector index is the top `SEC_W` address bits. Bit 6 does not change on such reads, and bit 2 inverts after each one, starting from 0.
- R9: In state code 4, a read of a sector that is clear in `susp_mask` returns `array_byte`, and neither toggle bit changes.
- R10: In state code 5, a read of a sector that is clear in `susp_mask` returns the program status of R3 and toggles bit 6 as in R5.
- R11: Any cycle in read mode clears both toggle bits, so the first status read of the next operation shows bit 6 = 0 and bit 2 = 0.
- R12: State codes 6 and 7 behave exactly as read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | Operation state code from the controller |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| fail_flag | input | 1 | Operation exceeded its time limit |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read byte address |
| susp_mask | input | 2**SEC_W | Sectors under erase or suspended |
| array_byte | input | 8 | Data read from the cell array |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | High for one cycle when `rd_data` is new |

## Verification
The hardest case to reach is a suspend state that alternates between reads of suspended and non-suspended sectors. In that case, bit 2 must advance only on reads of suspended sectors, bit 6 must advance only on program-status reads, and each bit must keep its value through the reads that belong to the other. The random phase keeps the state code fixed over runs of reads while it draws a fresh address and sector mask for every read, so these interleavings occur many times. Directed sequences then force the clear that happens on a return to read mode between two operations.

// File: rtl/flash_op_status_pkg.sv
package flash_op_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_PROG       = 3'd1,
    OP_ERASE_WAIT = 3'd2,
    OP_ERASE_RUN  = 3'd3,
    OP_SUSP_READ  = 3'd4,
    OP_SUSP_PROG  = 3'd5,
    OP_RSV6       = 3'd6,
    OP_RSV7       = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    V_ARRAY = 3'd0,
    V_PROG  = 3'd1,
    V_EWAIT = 3'd2,
    V_ERUN  = 3'd3,
    V_SUSP  = 3'd4
  } view_e;

  localparam int unsigned POLL_BIT  = 7;
  localparam int unsigned TOG_BIT   = 6;
  localparam int unsigned FAIL_BIT  = 5;
  localparam int unsigned START_BIT = 3;
  localparam int unsigned STOG_BIT  = 2;

endpackage

// File: rtl/fos_sector_hit.sv
module fos_sector_hit #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned SEC_W  = 3,
  localparam int unsigned NSEC  = 1 << SEC_W,
  localparam int unsigned SHIFT = ADDR_W - SEC_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSEC-1:0]   mask,
  output logic              hit
);
  logic [NSEC-1:0] in_sec;

  // One range comparator per sector; the selected sector's mask bit passes.
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(s) << SHIFT;
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(s + 1) << SHIFT;
    assign in_sec[s] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI) && mask[s];
  end

  assign hit = |in_sec;

  always_comb begin
    assert ($onehot0(in_sec)) else $error("a_r8_one_sector_hit");
  end
endmodule

// File: rtl/fos_view_sel.sv
module fos_view_sel
  import flash_op_status_pkg::*;
(
  input  op_e   op,
  input  logic  hit,
  output view_e view,
  output logic  idle
);
  always_comb begin
    view = V_ARRAY;
    idle = 1'b0;
    unique case (op)
      OP_PROG:       view = V_PROG;
      OP_ERASE_WAIT: view = V_EWAIT;
      OP_ERASE_RUN:  view = V_ERUN;
      OP_SUSP_READ:  view = hit ? V_SUSP : V_ARRAY;
      OP_SUSP_PROG:  view = hit ? V_SUSP : V_PROG;
      OP_IDLE, OP_RSV6, OP_RSV7: idle = 1'b1; // R12: reserved codes act as read mode
      default:       idle = 1'b1;
    endcase
  end
endmodule

// File: rtl/fos_toggle_bank.sv
module fos_toggle_bank (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step_busy,
  input  logic step_susp,
  output logic tog_busy,
  output logic tog_susp
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tog_busy <= 1'b0;
      tog_susp <= 1'b0;
    end else begin
      if (step_busy) tog_busy <= ~tog_busy;
      if (step_susp) tog_susp <= ~tog_susp;
    end
  end

  a_r5_busy_flips: assert property (@(posedge clk) disable iff (rst)
    (step_busy && !clr) |=> (tog_busy != $past(tog_busy)));
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (!step_busy && !clr) |=> $stable(tog_busy));
  a_r8_susp_flips: assert property (@(posedge clk) disable iff (rst)
    (step_susp && !clr) |=> (tog_susp != $past(tog_susp)));
  a_r6_susp_holds: assert property (@(posedge clk) disable iff (rst)
    (!step_susp && !clr) |=> $stable(tog_susp));
  a_r11_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!tog_busy && !tog_susp));
endmodule

// File: rtl/fos_status_fmt.sv
module fos_status_fmt
  import flash_op_status_pkg::*;
(
  input  view_e      view,
  input  logic       prog_msb,
  input  logic       fail_flag,
  input  logic       tog_busy,
  input  logic       tog_susp,
  input  logic [7:0] array_byte,
  output logic [7:0] byte_out
);
  always_comb begin
    byte_out = '0;
    unique case (view)
      V_PROG: begin
        byte_out[POLL_BIT] = ~prog_msb;
        byte_out[TOG_BIT]  = tog_busy;
        byte_out[FAIL_BIT] = fail_flag;
      end
      V_EWAIT, V_ERUN: begin
        byte_out[TOG_BIT]   = tog_busy;
        byte_out[FAIL_BIT]  = fail_flag;
        byte_out[START_BIT] = (view == V_ERUN);
      end
      V_SUSP: begin
        byte_out[POLL_BIT] = 1'b1;
        byte_out[TOG_BIT]  = tog_busy;
        byte_out[STOG_BIT] = tog_susp;
      end
      default: byte_out = array_byte;
    endcase
  end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_op_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned SEC_W  = 3,
  localparam int unsigned NSEC  = 1 << SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_state,
  input  logic              prog_msb,
  input  logic              fail_flag,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSEC-1:0]   susp_mask,
  input  logic [7:0]        array_byte,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  op_e        op;
  view_e      view;
  logic       hit, idle;
  logic       tog_busy, tog_susp;
  logic       step_busy, step_susp;
  logic [7:0] byte_nxt;

  assign op = op_e'(op_state);

  fos_sector_hit #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) hit_i (
    .addr(rd_addr), .mask(susp_mask), .hit(hit));

  fos_view_sel view_i (.op(op), .hit(hit), .view(view), .idle(idle));

  assign step_busy = rd_en && (view == V_PROG || view == V_EWAIT || view == V_ERUN);
  assign step_susp = rd_en && (view == V_SUSP);

  fos_toggle_bank tog_i (
    .clk(clk), .rst(rst), .clr(idle),
    .step_busy(step_busy), .step_susp(step_susp),
    .tog_busy(tog_busy), .tog_susp(tog_susp));

  fos_status_fmt fmt_i (
    .view(view), .prog_msb(prog_msb), .fail_flag(fail_flag),
    .tog_busy(tog_busy), .tog_susp(tog_susp),
    .array_byte(array_byte), .byte_out(byte_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= byte_nxt;
    end
  end

  a_r2_array_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_en && op_state == 3'd0) |=> (rd_data == $past(array_byte)));
  a_r3_prog_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_en && op_state == 3'd1) |=> (rd_data[7] == !$past(prog_msb)));
  a_r4_erase_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (op_state == 3'd2 || op_state == 3'd3)) |=> (rd_data[7] == 1'b0));
  a_r8_susp_status: assert property (@(posedge clk) disable iff (rst)
    (rd_en && view == V_SUSP) |=> (rd_data[7] && rd_data[6] == $past(tog_busy)));
endmodule

// File: tb/flash_op_status_tb_top.sv
`timescale 1ns/1ps
module flash_op_status_tb_top;
  localparam int AW = 19;
  localparam int SW = 3;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_state = '0;
  logic          prog_msb = 1'b0;
  logic          fail_flag = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [NS-1:0] susp_mask = '0;
  logic [7:0]    array_byte = '0;
  logic [7:0]    rd_data;
  logic          rd_valid;

  int checks = 0;
  int failures = 0;
  logic m6 = 1'b0, m2 = 1'b0;

  always #4 clk = ~clk;

  flash_op_status #(.ADDR_W(AW), .SEC_W(SW)) dut_i (.*);

  function automatic logic sec_hit(logic [AW-1:0] a, logic [NS-1:0] m);
    return m[a[AW-1 -: SW]];
  endfunction

  function automatic logic [7:0] exp_byte(logic [2:0] op, logic pm, logic [AW-1:0] a,
      logic [NS-1:0] m, logic [7:0] arr, logic f, logic t6, logic t2);
    logic h;
    h = sec_hit(a, m);
    case (op)
      3'd1: return {~pm, t6, f, 5'b0};
      3'd2: return {1'b0, t6, f, 5'b0};
      3'd3: return {1'b0, t6, f, 1'b0, 1'b1, 3'b0};
      3'd4: return h ? {1'b1, t6, 3'b0, t2, 2'b0} : arr;
      3'd5: return h ? {1'b1, t6, 3'b0, t2, 2'b0} : {~pm, t6, f, 5'b0};
      default: return arr;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Called at a negedge with inputs set; returns at the next negedge.
  task automatic cyc(logic r, string tag);
    logic [7:0] e;
    logic h;
    rd_en = r;
    e = exp_byte(op_state, prog_msb, rd_addr, susp_mask, array_byte, fail_flag, m6, m2);
    h = sec_hit(rd_addr, susp_mask);
    @(posedge clk);
    if (op_state == 3'd0 || op_state >= 3'd6) begin
      m6 = 1'b0; m2 = 1'b0;
    end else if (r) begin
      if ((op_state == 3'd4 || op_state == 3'd5) && h) m2 = ~m2;
      else if (op_state != 3'd4) m6 = ~m6;
    end
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " valid"}, {7'b0, rd_valid}, {7'b0, r});
    if (r) check(tag, rd_data, e);
  endtask

  task automatic rd(logic [2:0] op, logic [AW-1:0] a, logic [7:0] arr, string tag);
    op_state = op; rd_addr = a; array_byte = arr;
    cyc(1'b1, tag);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R1 reset data", rd_data, 8'h00);
    check("R1 reset valid", {7'b0, rd_valid}, 8'h00);
    rst = 1'b0;
    cyc(1'b0, "R1 idle");
    check("R1 after release", rd_data, 8'h00);

    rd(3'd0, 19'h12345, 8'hA5, "R2 idle read");
    rd(3'd0, 19'h00001, 8'h3C, "R2 idle read b2b");
    // program: back-to-back reads alternate bit 6
    prog_msb = 1'b1;
    rd(3'd1, 19'h00010, 8'hFF, "R3 R5 prog read0");
    rd(3'd1, 19'h00010, 8'hFF, "R5 prog read1");
    cyc(1'b0, "R6 gap");
    cyc(1'b0, "R6 gap");
    rd(3'd1, 19'h00010, 8'hFF, "R6 R5 prog read2");
    fail_flag = 1'b1;
    rd(3'd1, 19'h00010, 8'hFF, "R7 prog fail");
    rd(3'd1, 19'h00010, 8'hFF, "R7 prog fail toggles");
    fail_flag = 1'b0;
    rd(3'd0, 19'h00010, 8'h7E, "R3 back to array");
    // erase window then running, toggle cleared in between
    rd(3'd2, 19'h20000, 8'h00, "R4 R11 erase window");
    rd(3'd2, 19'h20000, 8'h00, "R4 erase window 2");
    rd(3'd3, 19'h20000, 8'h00, "R4 erase running");
    fail_flag = 1'b1;
    rd(3'd3, 19'h20000, 8'h00, "R7 erase fail");
    fail_flag = 1'b0;
    op_state = 3'd0; cyc(1'b0, "R11 clear");
    // suspend
    susp_mask = 8'b0000_0100;
    rd(3'd4, 19'h2ABCD, 8'h11, "R8 susp hit0");
    rd(3'd4, 19'h2ABCD, 8'h11, "R8 susp hit1");
    rd(3'd4, 19'h5ABCD, 8'h22, "R9 susp other sector");
    rd(3'd5, 19'h60000, 8'h33, "R10 susp prog other");
    rd(3'd5, 19'h2FFFF, 8'h44, "R8 susp prog hit");
    rd(3'd5, 19'h30000, 8'h55, "R10 susp prog boundary");
    rd(3'd6, 19'h2FFFF, 8'h66, "R12 code6");
    rd(3'd7, 19'h2FFFF, 8'h77, "R12 code7");
    rd(3'd1, 19'h00000, 8'h00, "R11 first read after idle");

    for (int blk = 0; blk < 150; blk++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      prog_msb = 1'($urandom);
      for (int k = 0; k < 8; k++) begin
        logic r;
        r = ($urandom_range(0, 3) != 0);
        op_state = op;
        rd_addr = AW'($urandom);
        susp_mask = NS'($urandom);
        array_byte = 8'($urandom);
        fail_flag = ($urandom_range(0, 7) == 0);
        cyc(r, "R2 R3 R4 R5 R8 R9 R10 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule